// File: doc/BRIEF.md
# Frame Buffer Host Window Decoder

This block opens a 64 KB host memory window onto a 512x512 frame of one-byte pixels (four 64 KB pages). A host address bus with separate read and write strobes is decoded against a window base. That base is chosen by a board strap pin together with a bank bit held in a control register. Inside the window, the byte offset is combined with a two-bit page number to form a linear offset. The offset is split into a major and a minor index, and the pair is optionally transposed, so consecutive host bytes walk either along a pixel row or down a pixel column.

Two control registers are loaded through a small write-only port. Host access reaches the pixel array only while a connect bit is set. With the bit clear, the block neither stores host writes nor drives read data. This lets several boards sit behind the same window. Geometry is set by `COORD_W`: a value of 9 gives the full 512x512 frame with a 64 KB window. The default of 5 (a 32x32 frame with a 256-byte window) keeps the internal array small. All numbers below are given for a general `COORD_W`, with N = 2^COORD_W and W = N*N/4.

Top module: `fb_window_dec`

## Requirements
- R1: After reset both control registers read as zero in effect: the window is disconnected, page 0 is selected, rotation is off, and `host_rdata_en` stays low.
- R2: The window starts at host address 0xA0000 (bank bit 0, `strap_hi` 0), 0xB0000 (bank 0, strap 1), 0xD0000 (bank 1, strap 0) or 0xE0000 (bank 1, strap 1), and spans W bytes.
- R3: A host read or write whose address lies outside the selected window is ignored: nothing is stored and `host_rdata_en` stays low.
- R4: While the connect bit (bit 1 of control register 1) is 0, host writes are dropped and host reads leave `host_rdata_en` low.
- R5: Bits 1:0 of control register 0 select the page. The linear offset is page*W plus the window offset, so page p reaches frame offsets p*W to p*W+W-1.
- R6: With the rotate bit (bit 2 of control register 0) clear, linear offset L addresses pixel x = L mod N, y = L div N (row-major).
- R7: With the rotate bit set, linear offset L addresses pixel x = L div N, y = L mod N (column-major).
- R8: A read strobe that hits the connected window yields its data with `host_rdata_en` high in the cycle after the strobe. The enable drops in the cycle after a cycle with no such read.
- R9: A write that hits the connected window stores its byte at the clock edge of the strobe, so a read issued in the following cycle returns the new value.
- R10: A control port write with `ctl_sel` 0 loads register 0 and with `ctl_sel` 1 loads register 1. Bit 0 of register 1 is the bank bit. A cycle without `ctl_wr` leaves both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_hi | input | 1 | Board strap, 1 selects the upper base of each bank |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_sel | input | 1 | Control register select (0 or 1) |
| ctl_wdata | input | 8 | Control register write data |
| host_addr | input | 20 | Host memory address |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, zero when not driving |
| host_rdata_en | output | 1 | High when the block drives the host data bus |

## Verification
The hardest situation to reach is proof that one frame location is reached through both orderings. Its rotated address must land on the pixel that its row-major address names, on every page. The stimulus first fills the entire frame through row-major writes with a known pattern, so every byte has a known value. Random mixes of page, rotation, bank, strap, connect state and in-window or out-of-window addresses then follow. Each read is compared against a pixel model that the bench indexes by (x,y). Disconnected and outside-window writes are followed by reads of the same address once the window is reconnected.

// File: rtl/fb_win_pkg.sv
package fb_win_pkg;

  // Control register field positions
  localparam int CTL0_PAGE_LSB = 0;
  localparam int CTL0_ROT_BIT  = 2;
  localparam int CTL1_BANK_BIT = 0;
  localparam int CTL1_CONN_BIT = 1;

  typedef struct packed {
    logic [1:0] page;
    logic       rotate;
    logic       bank_sel;
    logic       connect;
  } fb_ctl_t;

  // Top address nibble of the window base
  function automatic logic [3:0] win_base_nibble(input logic bank_sel, input logic strap_hi);
    logic [3:0] nib;
    case ({bank_sel, strap_hi})
      2'b00:   nib = 4'hA;
      2'b01:   nib = 4'hB;
      2'b10:   nib = 4'hD;
      default: nib = 4'hE;
    endcase
    return nib;
  endfunction

endpackage

// File: rtl/fb_ctl_regs.sv
module fb_ctl_regs
  import fb_win_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              sel,
  input  logic [DATA_W-1:0] wdata,
  output fb_ctl_t           ctl
);

  logic [DATA_W-1:0] reg0_q, reg0_d;
  logic [DATA_W-1:0] reg1_q, reg1_d;
  logic              reg0_en, reg1_en;

  always_comb begin
    reg0_en = wr && !sel;
    reg1_en = wr &&  sel;
    reg0_d  = reg0_en ? wdata : reg0_q;
    reg1_d  = reg1_en ? wdata : reg1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg0_q <= '0;
      reg1_q <= '0;
    end else begin
      reg0_q <= reg0_d;
      reg1_q <= reg1_d;
    end
  end

  always_comb begin
    ctl.page     = reg0_q[CTL0_PAGE_LSB +: 2];
    ctl.rotate   = reg0_q[CTL0_ROT_BIT];
    ctl.bank_sel = reg1_q[CTL1_BANK_BIT];
    ctl.connect  = reg1_q[CTL1_CONN_BIT];
  end

  // R10
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ($stable(reg0_q) && $stable(reg1_q)));

endmodule

// File: rtl/fb_addr_xlate.sv
module fb_addr_xlate
  import fb_win_pkg::*;
#(
  parameter int HOST_AW = 20,
  parameter int COORD_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [HOST_AW-1:0]   host_addr,
  input  logic                 strap_hi,
  input  fb_ctl_t              ctl,
  output logic                 hit,
  output logic [2*COORD_W-1:0] mem_idx
);

  localparam int LIN_W  = 2 * COORD_W;
  localparam int WIN_AW = LIN_W - 2;

  logic [LIN_W-1:0]   linear;
  logic [COORD_W-1:0] major, minor;
  logic               nib_hit, gap_zero;

  assign nib_hit = (host_addr[HOST_AW-1 -: 4] == win_base_nibble(ctl.bank_sel, strap_hi));

  generate
    if (WIN_AW < HOST_AW - 4) begin : g_gap
      assign gap_zero = (host_addr[HOST_AW-5:WIN_AW] == '0);
    end else begin : g_nogap
      assign gap_zero = 1'b1;
    end
  endgenerate

  always_comb begin
    hit     = nib_hit && gap_zero;
    linear  = {ctl.page, host_addr[WIN_AW-1:0]};
    major   = linear[LIN_W-1:COORD_W];
    minor   = linear[COORD_W-1:0];
    mem_idx = ctl.rotate ? {minor, major} : {major, minor};
  end

  // R6
  row_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.rotate |-> (mem_idx[LIN_W-1 -: 2] == ctl.page));

  // R7
  col_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.rotate |-> (mem_idx[COORD_W-1 -: 2] == ctl.page));

endmodule

// File: rtl/fb_pixel_mem.sv
module fb_pixel_mem #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[idx] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (re) begin
      rdata <= mem[idx];
    end
  end

endmodule

// File: rtl/fb_window_dec.sv
module fb_window_dec
  import fb_win_pkg::*;
#(
  parameter int HOST_AW = 20,
  parameter int COORD_W = 5,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strap_hi,
  input  logic               ctl_wr,
  input  logic               ctl_sel,
  input  logic [7:0]         ctl_wdata,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic               host_rd,
  input  logic               host_wr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  output logic               host_rdata_en
);

  localparam int MEM_AW = 2 * COORD_W;

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  fb_ctl_t            ctl;
  logic               hit, access_ok, mem_we, mem_re;
  logic [MEM_AW-1:0]  mem_idx;
  logic [DATA_W-1:0]  mem_rdata;
  logic               rd_en_q, rd_en_d;

  fb_ctl_regs #(.DATA_W(8)) u_regs (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr    (ctl_wr),
    .sel   (ctl_sel),
    .wdata (ctl_wdata),
    .ctl   (ctl)
  );

  fb_addr_xlate #(.HOST_AW(HOST_AW), .COORD_W(COORD_W)) u_xlate (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .host_addr (host_addr),
    .strap_hi  (strap_hi),
    .ctl       (ctl),
    .hit       (hit),
    .mem_idx   (mem_idx)
  );

  always_comb begin
    access_ok = hit && ctl.connect;
    mem_we    = host_wr && access_ok;
    mem_re    = host_rd && access_ok;
    rd_en_d   = mem_re;
  end

  fb_pixel_mem #(.AW(MEM_AW), .DW(DATA_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .re    (mem_re),
    .idx   (mem_idx),
    .wdata (host_wdata),
    .rdata (mem_rdata)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_en_q <= 1'b0;
    end else begin
      rd_en_q <= rd_en_d;
    end
  end

  assign host_rdata_en = rd_en_q;
  assign host_rdata    = rd_en_q ? mem_rdata : '0;

  // R8
  rd_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    host_rdata_en |-> $past(host_rd));

  // R4
  disconnected_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ctl.connect |=> !host_rdata_en);

  // R3
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !hit |=> !host_rdata_en);

endmodule

// File: tb/fb_window_dec_tb.sv
module fb_window_dec_tb;

  localparam int HOST_AW = 20;
  localparam int C       = 5;
  localparam int N       = 1 << C;
  localparam int WIN     = (N * N) / 4;
  localparam int FRAME   = N * N;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       strap_hi;
  logic       ctl_wr, ctl_sel;
  logic [7:0] ctl_wdata;
  logic [HOST_AW-1:0] host_addr;
  logic       host_rd, host_wr;
  logic [7:0] host_wdata;
  logic [7:0] host_rdata;
  logic       host_rdata_en;

  always #10 clk = ~clk;

  fb_window_dec #(.HOST_AW(HOST_AW), .COORD_W(C), .DATA_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .strap_hi(strap_hi),
    .ctl_wr(ctl_wr), .ctl_sel(ctl_sel), .ctl_wdata(ctl_wdata),
    .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rdata_en(host_rdata_en)
  );

  int   checks = 0;
  int   errors = 0;
  logic [7:0] model [FRAME];
  logic [7:0] m_ctl0, m_ctl1;
  logic       m_strap;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int base_of(input logic bank, input logic strap);
    if (!bank) return strap ? 32'hB0000 : 32'hA0000;
    return strap ? 32'hE0000 : 32'hD0000;
  endfunction

  function automatic bit in_window(input int addr);
    int b;
    b = base_of(m_ctl1[0], m_strap);
    return (addr >= b) && (addr < b + WIN);
  endfunction

  function automatic bit reaches(input int addr);
    return in_window(addr) && m_ctl1[1];
  endfunction

  function automatic int pix_of(input int addr);
    int lin, maj, mnr, x, y;
    lin = int'(m_ctl0[1:0]) * WIN + (addr % WIN);
    maj = lin / N;
    mnr = lin % N;
    if (m_ctl0[2]) begin x = maj; y = mnr; end
    else           begin x = mnr; y = maj; end
    return y * N + x;
  endfunction

  task automatic ctl_write(input bit sel, input logic [7:0] v);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_sel = sel; ctl_wdata = v;
    @(negedge clk);
    ctl_wr = 1'b0;
    if (sel) m_ctl1 = v; else m_ctl0 = v;
  endtask

  task automatic set_strap(input logic s);
    @(negedge clk);
    strap_hi = s;
    m_strap  = s;
  endtask

  task automatic hwrite(input int addr, input logic [7:0] d);
    @(negedge clk);
    host_addr = addr[HOST_AW-1:0]; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    if (reaches(addr)) model[pix_of(addr)] = d;
  endtask

  task automatic hread(input int addr, output logic [7:0] d, output logic en);
    @(negedge clk);
    host_addr = addr[HOST_AW-1:0]; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    d  = host_rdata;
    en = host_rdata_en;
  endtask

  task automatic read_check(input int addr, input string tag);
    logic [7:0] d;
    logic en;
    hread(addr, d, en);
    if (reaches(addr)) begin
      chk(en === 1'b1, tag, int'(en), 1);
      chk(d === model[pix_of(addr)], tag, int'(d), int'(model[pix_of(addr)]));
    end else begin
      chk(en === 1'b0, tag, int'(en), 0);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    logic en;
    int   seed;
    seed = 32'h5EED1234;
    void'($urandom(seed));
    rst_n = 1'b0; strap_hi = 1'b0; m_strap = 1'b0;
    ctl_wr = 1'b0; ctl_sel = 1'b0; ctl_wdata = '0;
    host_addr = '0; host_rd = 1'b0; host_wr = 1'b0; host_wdata = '0;
    m_ctl0 = '0; m_ctl1 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state, disconnected, no drive
    chk(host_rdata_en === 1'b0, "R1 idle", int'(host_rdata_en), 0);
    hread(32'hA0000, d, en);
    chk(en === 1'b0, "R1 read after reset", int'(en), 0);

    // Connect at bank 0 / strap 0 and fill whole frame row-major via pages (R5, R6)
    ctl_write(1'b1, 8'h02);
    for (int p = 0; p < 4; p++) begin
      ctl_write(1'b0, 8'(p));
      for (int o = 0; o < WIN; o++) hwrite(32'hA0000 + o, 8'((p * WIN + o) * 7 + 3));
    end
    for (int p = 0; p < 4; p++) begin
      ctl_write(1'b0, 8'(p));
      read_check(32'hA0000 + 5, "R5 page read");
      read_check(32'hA0000 + WIN - 1, "R6 row end");
    end

    // R7: rotated read of pixel (3,9) lands where row-major wrote it
    ctl_write(1'b0, 8'h04);
    hread(32'hA0000 + 3 * N + 9, d, en);
    chk(en === 1'b1 && d === 8'((9 * N + 3) * 7 + 3), "R7 transpose", int'(d), (9 * N + 3) * 7 + 3);
    ctl_write(1'b0, 8'h07);
    read_check(32'hA0000 + 1, "R7 rotated page3");

    // R8: enable drops in the cycle after the data cycle
    ctl_write(1'b0, 8'h00);
    hread(32'hA0000 + 2, d, en);
    chk(en === 1'b1, "R8 data cycle", int'(en), 1);
    @(negedge clk);
    chk(host_rdata_en === 1'b0, "R8 drop", int'(host_rdata_en), 0);

    // R9: write then read next cycle
    hwrite(32'hA0000 + 4, 8'h5A);
    read_check(32'hA0000 + 4, "R9 read after write");

    // R2: all four bases
    for (int b = 0; b < 4; b++) begin
      set_strap(b[0]);
      ctl_write(1'b1, {6'd0, 1'b1, b[1]});
      read_check(base_of(b[1], b[0]) + 7, "R2 base hit");
      read_check(base_of(!b[1], b[0]) + 7, "R2 other bank miss");
    end

    // R3: outside window write ignored
    set_strap(1'b0);
    ctl_write(1'b1, 8'h02);
    hwrite(32'hA0000 + WIN, 8'hEE);
    read_check(32'hA0000 + WIN, "R3 outside read");
    read_check(32'hA0000, "R3 inside unaffected");

    // R4: disconnected write dropped, checked after reconnect
    ctl_write(1'b1, 8'h00);
    hwrite(32'hA0000 + 6, 8'hC3);
    read_check(32'hA0000 + 6, "R4 disconnected read");
    ctl_write(1'b1, 8'h02);
    read_check(32'hA0000 + 6, "R4 write dropped");

    // R10: register 1 bank bit moves window, register 0 untouched
    ctl_write(1'b0, 8'h01);
    ctl_write(1'b1, 8'h03);
    read_check(32'hD0000 + 9, "R10 bank bit");
    read_check(32'hA0000 + 9, "R10 old base miss");

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      int r, b, a;
      r = $urandom_range(99);
      if (r < 6) ctl_write(1'b0, 8'($urandom_range(7)));
      else if (r < 10) ctl_write(1'b1, {6'd0, ($urandom_range(3) != 0), 1'($urandom_range(1))});
      else if (r < 12) set_strap(1'($urandom_range(1)));
      else begin
        b = base_of(1'($urandom_range(1)), 1'($urandom_range(1)));
        a = ($urandom_range(9) == 0) ? b + $urandom_range(2 * WIN - 1) : b + $urandom_range(WIN - 1);
        if (r < 50) hwrite(a, 8'($urandom_range(255)));
        else read_check(a, "R6 R7 random read");
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule